// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency Pipeline FFT Stage

This block is one stage of a streaming radix-2 decimation-in-frequency FFT of size N = 2^LOG_N. It takes one complex sample on each clock where `en` is high, and after a fixed pipeline delay it gives one complex result on each enabled clock. Frames are counted from reset. The first enabled sample after reset is position 0 of frame 0, and frames follow each other with no gap.

Inside each frame, the first half of the samples goes into a buffer of N/2 entries. In the second half, each fresh sample b_k is paired with the buffered sample a_k from the same position k. The pair goes through a four-register butterfly. The butterfly produces the sum a_k + b_k and the twiddled difference (a_k - b_k)·W_k, where W_k = exp(-j2πk/N) is taken from a constant table. A frame-start marker runs alongside the pair data through the butterfly. When it comes out, it starts an output sequencer. The sequencer sends all N/2 sums first and holds the differences in a second buffer. It then sends the held differences during the half-frame in which the butterfly has no new data. The output therefore never has a gap.

Top module: `dif_fft_stage`

## Requirements
- R1: A synchronous, active-high `rst` clears `dout` and `dout_sof` to zero. The next enabled sample after reset is frame position 0.
- R2: On any clock with `en` low, no state advances and both outputs keep their values, however long the stall lasts.
- R3: `din` packs the real part in bits [2*DATA_W-1:DATA_W] and the imaginary part in bits [DATA_W-1:0]. `dout` uses the same layout with OUT_W = DATA_W+1 bit fields. All values are two's complement.
- R4: Output positions k = 0..N/2-1 of a frame carry a_k + b_k exactly, where a_k is input position k and b_k is input position k+N/2 of the same frame.
- R5: Output positions N/2+k carry (a_k - b_k)·W_k. The coefficient parts are cos(2πk/N) and -sin(2πk/N), each scaled by 2^(COEF_W-2) and rounded to nearest with halves away from zero. Each product sum is rounded by adding 2^(COEF_W-3) and shifting right arithmetically by COEF_W-2.
- R6: Output position 0 of frame 0 appears on the enabled edge that accepts input number N/2+4, counting from 0 after reset. Before that edge, `dout` stays zero.
- R7: After the first output, every enabled edge produces the next output position, wrapping from N-1 to position 0 of the next frame.
- R8: `dout_sof` is 0 until the first output. After that it is 1 exactly while position 0 of a frame is on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; one sample accepted per high cycle |
| din | input | 2*DATA_W | Input sample {re, im} |
| dout | output | 2*(DATA_W+1) | Output sample {re, im} |
| dout_sof | output | 1 | High on the first output sample of each frame |

## Verification
The bench builds the stage with LOG_N=3 and DATA_W=COEF_W=10. The resulting 8-point frames are short, so one run crosses many frame boundaries, wraps of the park buffer, and sync realignments. The four twiddles include the exact quarter-turn value, whose cosine must round to zero. The coefficient scale is small enough that the rounding of the products is visible in every difference result. Enable is held continuous, random, and stalled for long stretches, and a reset lands in the middle of a frame. Every clock is compared against an index-based model of the transform.

// File: rtl/dif_fft_pkg.sv
package dif_fft_pkg;

   // Scaled, rounded (half away from zero) cosine or sine of 2*pi*k/2^log_n.
   function automatic int tw_scaled(input int k, input int log_n,
                                    input int frac_bits, input bit want_sin);
      real ang;
      real v;
      ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(64'd1 << log_n);
      v   = want_sin ? $sin(ang) : $cos(ang);
      v   = v * real'(64'd1 << frac_bits);
      if (v >= 0.0) return $rtoi($floor(v + 0.5));
      else          return -$rtoi($floor(-v + 0.5));
   endfunction

endpackage

// File: rtl/dif_twiddle_rom.sv
module dif_twiddle_rom #(
   parameter int LOG_N  = 6,
   parameter int COEF_W = 14
) (
   input  logic [LOG_N-2:0]          idx,
   output logic signed [COEF_W-1:0]  w_re,
   output logic signed [COEF_W-1:0]  w_im
);
   import dif_fft_pkg::*;

   localparam int HALF = 1 << (LOG_N - 1);
   localparam int FRAC = COEF_W - 2;

   logic signed [COEF_W-1:0] tab_re [HALF];
   logic signed [COEF_W-1:0] tab_im [HALF];

   for (genvar g = 0; g < HALF; g++) begin : g_tab
      localparam int CV = tw_scaled(g, LOG_N, FRAC, 1'b0);
      localparam int SV = tw_scaled(g, LOG_N, FRAC, 1'b1);
      assign tab_re[g] = COEF_W'(CV);
      assign tab_im[g] = COEF_W'(-SV);
   end

   assign w_re = tab_re[idx];
   assign w_im = tab_im[idx];
endmodule

// File: rtl/dif_input_buffer.sv
module dif_input_buffer #(
   parameter int LOG_N  = 6,
   parameter int DATA_W = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] in_re,
   input  logic signed [DATA_W-1:0] in_im,
   output logic signed [DATA_W-1:0] a_re,
   output logic signed [DATA_W-1:0] a_im,
   output logic signed [DATA_W-1:0] b_re,
   output logic signed [DATA_W-1:0] b_im,
   output logic [LOG_N-2:0]         pos,
   output logic                     pair_sync
);
   localparam int HALF = 1 << (LOG_N - 1);

   logic [LOG_N-1:0]         icnt;
   logic [LOG_N-2:0]         slot;
   logic                     second_half;
   logic signed [DATA_W-1:0] hold_re [HALF];
   logic signed [DATA_W-1:0] hold_im [HALF];

   assign slot        = icnt[LOG_N-2:0];
   assign second_half = icnt[LOG_N-1];

   always_ff @(posedge clk) begin
      if (en && !second_half) begin
         hold_re[slot] <= in_re;
         hold_im[slot] <= in_im;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         icnt      <= '0;
         a_re      <= '0;
         a_im      <= '0;
         b_re      <= '0;
         b_im      <= '0;
         pos       <= '0;
         pair_sync <= 1'b0;
      end else if (en) begin
         icnt      <= icnt + 1'b1;
         a_re      <= hold_re[slot];
         a_im      <= hold_im[slot];
         b_re      <= in_re;
         b_im      <= in_im;
         pos       <= slot;
         pair_sync <= (icnt == LOG_N'(HALF));
      end
   end
endmodule

// File: rtl/dif_butterfly.sv
module dif_butterfly #(
   parameter int DATA_W = 12,
   parameter int COEF_W = 14,
   parameter int OUT_W  = DATA_W + 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] a_re,
   input  logic signed [DATA_W-1:0] a_im,
   input  logic signed [DATA_W-1:0] b_re,
   input  logic signed [DATA_W-1:0] b_im,
   input  logic signed [COEF_W-1:0] w_re,
   input  logic signed [COEF_W-1:0] w_im,
   input  logic                     in_sync,
   output logic signed [OUT_W-1:0]  sum_re,
   output logic signed [OUT_W-1:0]  sum_im,
   output logic signed [OUT_W-1:0]  dif_re,
   output logic signed [OUT_W-1:0]  dif_im,
   output logic                     out_sync
);
   localparam int DW1   = DATA_W + 1;
   localparam int PW    = DW1 + COEF_W;
   localparam int FRAC  = COEF_W - 2;
   localparam int RND_I = 1 << (FRAC - 1);

   logic signed [DW1-1:0]    s2_re, s2_im, d2_re, d2_im;
   logic signed [COEF_W-1:0] w2_re, w2_im;
   logic                     sy2, sy3;
   logic signed [DW1-1:0]    s3_re, s3_im;
   logic signed [PW-1:0]     p_rr, p_ii, p_ri, p_ir;
   logic signed [PW:0]       t_re, t_im;

   assign t_re = (PW+1)'(p_rr) - (PW+1)'(p_ii) + (PW+1)'(RND_I);
   assign t_im = (PW+1)'(p_ri) + (PW+1)'(p_ir) + (PW+1)'(RND_I);

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_re <= '0; s2_im <= '0; d2_re <= '0; d2_im <= '0;
         w2_re <= '0; w2_im <= '0; sy2 <= 1'b0;
         s3_re <= '0; s3_im <= '0;
         p_rr <= '0; p_ii <= '0; p_ri <= '0; p_ir <= '0; sy3 <= 1'b0;
         sum_re <= '0; sum_im <= '0; dif_re <= '0; dif_im <= '0;
         out_sync <= 1'b0;
      end else if (en) begin
         // add / subtract
         s2_re <= DW1'(a_re) + DW1'(b_re);
         s2_im <= DW1'(a_im) + DW1'(b_im);
         d2_re <= DW1'(a_re) - DW1'(b_re);
         d2_im <= DW1'(a_im) - DW1'(b_im);
         w2_re <= w_re;
         w2_im <= w_im;
         sy2   <= in_sync;
         // partial products
         p_rr  <= PW'(d2_re) * PW'(w2_re);
         p_ii  <= PW'(d2_im) * PW'(w2_im);
         p_ri  <= PW'(d2_re) * PW'(w2_im);
         p_ir  <= PW'(d2_im) * PW'(w2_re);
         s3_re <= s2_re;
         s3_im <= s2_im;
         sy3   <= sy2;
         // combine and round
         dif_re   <= OUT_W'(t_re >>> FRAC);
         dif_im   <= OUT_W'(t_im >>> FRAC);
         sum_re   <= OUT_W'(s3_re);
         sum_im   <= OUT_W'(s3_im);
         out_sync <= sy3;
      end
   end
endmodule

// File: rtl/dif_output_reorder.sv
module dif_output_reorder #(
   parameter int LOG_N = 6,
   parameter int OUT_W = 13
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic signed [OUT_W-1:0] sum_re,
   input  logic signed [OUT_W-1:0] sum_im,
   input  logic signed [OUT_W-1:0] dif_re,
   input  logic signed [OUT_W-1:0] dif_im,
   input  logic                    bf_sync,
   output logic signed [OUT_W-1:0] o_re,
   output logic signed [OUT_W-1:0] o_im,
   output logic                    o_sof
);
   localparam int HALF = 1 << (LOG_N - 1);

   logic [LOG_N-1:0]        ocnt;
   logic [LOG_N-1:0]        opos;
   logic                    started;
   logic                    live;
   logic signed [OUT_W-1:0] park_re [HALF];
   logic signed [OUT_W-1:0] park_im [HALF];

   assign opos = bf_sync ? '0 : ocnt;
   assign live = bf_sync | started;

   always_ff @(posedge clk) begin
      if (en && live && !opos[LOG_N-1]) begin
         park_re[opos[LOG_N-2:0]] <= dif_re;
         park_im[opos[LOG_N-2:0]] <= dif_im;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ocnt    <= '0;
         started <= 1'b0;
         o_re    <= '0;
         o_im    <= '0;
         o_sof   <= 1'b0;
      end else if (en && live) begin
         started <= 1'b1;
         ocnt    <= opos + 1'b1;
         o_sof   <= (opos == '0);
         if (!opos[LOG_N-1]) begin
            o_re <= sum_re;
            o_im <= sum_im;
         end else begin
            o_re <= park_re[opos[LOG_N-2:0]];
            o_im <= park_im[opos[LOG_N-2:0]];
         end
      end
   end
endmodule

// File: rtl/dif_fft_stage.sv
module dif_fft_stage #(
   parameter int LOG_N  = 6,
   parameter int DATA_W = 12,
   parameter int COEF_W = 14,
   parameter int OUT_W  = DATA_W + 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  en,
   input  logic [2*DATA_W-1:0]   din,
   output logic [2*OUT_W-1:0]    dout,
   output logic                  dout_sof
);
   if (LOG_N < 2) begin : g_bad_size
      $error("dif_fft_stage: LOG_N must be at least 2");
   end
   if (COEF_W < 3) begin : g_bad_coef
      $error("dif_fft_stage: COEF_W must be at least 3");
   end
   if (OUT_W != DATA_W + 1) begin : g_bad_out
      $error("dif_fft_stage: OUT_W must equal DATA_W + 1");
   end

   logic signed [DATA_W-1:0] a_re, a_im, b_re, b_im;
   logic [LOG_N-2:0]         pos;
   logic                     pair_sync;
   logic signed [COEF_W-1:0] w_re, w_im;
   logic signed [OUT_W-1:0]  sum_re, sum_im, dif_re, dif_im;
   logic                     bf_sync;
   logic signed [OUT_W-1:0]  o_re, o_im;

   dif_input_buffer #(.LOG_N(LOG_N), .DATA_W(DATA_W)) u_inbuf (
      .clk(clk), .rst(rst), .en(en),
      .in_re(din[2*DATA_W-1:DATA_W]), .in_im(din[DATA_W-1:0]),
      .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .pos(pos), .pair_sync(pair_sync)
   );

   dif_twiddle_rom #(.LOG_N(LOG_N), .COEF_W(COEF_W)) u_rom (
      .idx(pos), .w_re(w_re), .w_im(w_im)
   );

   dif_butterfly #(.DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_bfly (
      .clk(clk), .rst(rst), .en(en),
      .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .w_re(w_re), .w_im(w_im), .in_sync(pair_sync),
      .sum_re(sum_re), .sum_im(sum_im), .dif_re(dif_re), .dif_im(dif_im),
      .out_sync(bf_sync)
   );

   dif_output_reorder #(.LOG_N(LOG_N), .OUT_W(OUT_W)) u_reord (
      .clk(clk), .rst(rst), .en(en),
      .sum_re(sum_re), .sum_im(sum_im), .dif_re(dif_re), .dif_im(dif_im),
      .bf_sync(bf_sync),
      .o_re(o_re), .o_im(o_im), .o_sof(dout_sof)
   );

   assign dout = {o_re, o_im};
endmodule

// File: rtl/dif_fft_stage_chk.sv
module dif_fft_stage_chk #(
   parameter int LOG_N  = 6,
   parameter int DOUT_W = 26
) (
   input logic              clk,
   input logic              rst,
   input logic              en,
   input logic [DOUT_W-1:0] dout,
   input logic              dout_sof
);
   localparam int N   = 1 << LOG_N;
   localparam int LAT = N / 2 + 4;

   logic              past_ok = 1'b0;
   logic              seen;
   logic [15:0]       ecnt;
   logic [LOG_N+1:0]  gap;

   always_ff @(posedge clk) begin
      past_ok <= 1'b1;
      if (rst) begin
         seen <= 1'b0;
         ecnt <= '0;
         gap  <= '0;
      end else if (en) begin
         seen <= seen | dout_sof;
         if (ecnt != 16'hFFFF) ecnt <= ecnt + 1'b1;
         if (dout_sof) gap <= (LOG_N+2)'(1);
         else if (gap != '1) gap <= gap + 1'b1;
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(rst)) |-> (dout == '0 && !dout_sof));

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst) && !$past(en)) |-> ($stable(dout) && $stable(dout_sof)));

   // R6
   first_sof_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(dout_sof) && !seen) |-> (ecnt == 16'(LAT + 1)));

   // R7
   sof_period_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(dout_sof) && seen) |-> (gap == (LOG_N+2)'(N)));

   // R8
   sof_on_enable_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $rose(dout_sof)) |-> $past(en));
endmodule

bind dif_fft_stage dif_fft_stage_chk #(.LOG_N(LOG_N), .DOUT_W(2*OUT_W)) u_chk (
   .clk(clk), .rst(rst), .en(en), .dout(dout), .dout_sof(dout_sof)
);

// File: tb/sim_dif_fft_stage.sv
`timescale 1ns/1ps
module sim_dif_fft_stage;
   localparam int LOG_N  = 3;
   localparam int DATA_W = 10;
   localparam int COEF_W = 10;
   localparam int OUT_W  = DATA_W + 1;
   localparam int N      = 1 << LOG_N;
   localparam int HALF   = N / 2;
   localparam int LAT    = HALF + 4;
   localparam int FRAC   = COEF_W - 2;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                en  = 1'b0;
   logic [2*DATA_W-1:0] din = '0;
   wire  [2*OUT_W-1:0]  dout;
   wire                 dout_sof;

   dif_fft_stage #(.LOG_N(LOG_N), .DATA_W(DATA_W), .COEF_W(COEF_W)) u0 (
      .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout), .dout_sof(dout_sof)
   );

   always #2 clk = ~clk;

   int               n_chk = 0;
   int               n_bad = 0;
   int               t = 0;
   int               xr [4096];
   int               xi [4096];
   logic [2*OUT_W-1:0] exp_dout = '0;
   logic             exp_sof = 1'b0;
   string            exp_tag = "R1 reset";
   bit               finished = 1'b0;

   function automatic longint coef(input int k, input bit im_part);
      real a, v;
      a = 2.0 * 3.14159265358979323846 * real'(k) / real'(N);
      v = im_part ? -$sin(a) : $cos(a);
      v = v * real'(1 << FRAC);
      if (v >= 0.0) return longint'($rtoi(v + 0.5));
      else          return -longint'($rtoi(-v + 0.5));
   endfunction

   function automatic int rv();
      return int'($urandom_range(0, 511)) - 256;
   endfunction

   task automatic compare();
      n_chk++;
      if (dout !== exp_dout || dout_sof !== exp_sof) begin
         n_bad++;
         $display("FAIL %s: dout=%h sof=%b expected dout=%h sof=%b",
                  exp_tag, dout, dout_sof, exp_dout, exp_sof);
      end
   endtask

   // One clock: compare at the falling edge, then drive and advance the model.
   task automatic cyc(input bit r, input bit e, input int re, input int im);
      int idx, f, j, k, ar, ai, br, bi;
      longint dr, di, wr, wi, pr, pi;
      @(negedge clk);
      compare();
      rst = r;
      en  = e;
      din = {DATA_W'(re), DATA_W'(im)};
      if (r) begin
         exp_dout = '0; exp_sof = 1'b0; t = 0; exp_tag = "R1 reset";
      end else if (!e) begin
         exp_tag = "R2 stall";
      end else begin
         xr[t] = re; xi[t] = im;
         idx = t - LAT;
         if (idx < 0) begin
            exp_tag = "R6 latency";
         end else begin
            f = idx / N; j = idx % N; k = j % HALF;
            ar = xr[f*N + k];        ai = xi[f*N + k];
            br = xr[f*N + HALF + k]; bi = xi[f*N + HALF + k];
            exp_sof = (j == 0);
            if (j < HALF) begin
               exp_dout = {OUT_W'(ar + br), OUT_W'(ai + bi)};
               exp_tag  = "R4 R3 R7 R8";
            end else begin
               dr = ar - br; di = ai - bi;
               wr = coef(k, 1'b0); wi = coef(k, 1'b1);
               pr = (dr*wr - di*wi + (64'sd1 <<< (FRAC-1))) >>> FRAC;
               pi = (dr*wi + di*wr + (64'sd1 <<< (FRAC-1))) >>> FRAC;
               exp_dout = {OUT_W'(pr), OUT_W'(pi)};
               exp_tag  = "R5 R3 R7 R8";
            end
         end
         t++;
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) cyc(1'b1, 1'b0, 0, 0);          // R1 reset state
      repeat (4) cyc(1'b0, 1'b0, 0, 0);          // R2 idle before data
      repeat (5*N) cyc(1'b0, 1'b1, rv(), rv());  // continuous random frames
      for (int i = 0; i < N; i++)                // impulse frame
         cyc(1'b0, 1'b1, (i == 0) ? 200 : 0, (i == 0) ? -100 : 0);
      for (int i = 0; i < N; i++) cyc(1'b0, 1'b1, 150, -75);   // DC frame
      for (int i = 0; i < N; i++)                // extreme differences
         cyc(1'b0, 1'b1, (i < HALF) ? 255 : -256, (i < HALF) ? -256 : 255);
      for (int i = 0; i < 6*N; i++) begin        // random stalls
         cyc(1'b0, 1'b1, rv(), rv());
         if ($urandom_range(0, 1) == 1) cyc(1'b0, 1'b0, rv(), rv());
         if (i == 3*N + 2) repeat (50) cyc(1'b0, 1'b0, rv(), rv());
      end
      repeat (3) cyc(1'b0, 1'b1, rv(), rv());    // mid-frame restart
      repeat (2) cyc(1'b1, 1'b1, rv(), rv());    // R1 reset while enabled
      repeat (5*N) cyc(1'b0, 1'b1, rv(), rv());
      repeat (3) cyc(1'b0, 1'b0, 0, 0);
      @(negedge clk);
      compare();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end
endmodule